// File: doc/BRIEF.md
# Reservation Station Array with Broadcast Wakeup

This block is the instruction buffer of a dynamically scheduled core that renames registers by copying values. It holds a small, fixed set of stations, each typed for one kind of execution unit. An in-order front end dispatches one instruction per cycle into a free station of the matching type. Each operand arrives either as a value, marked by a zero tag, or as the tag of the station that will produce it. Stalls happen only when every station of the needed type is taken.

Completed results come back on a single result bus that carries a tag and a value. Every station that is waiting on that tag takes the value and clears its tag. A station whose last missing operand arrives on the bus is reported as ready in that same cycle, and the bus value is forwarded on its issue outputs. Select logic outside the block picks from the ready mask and acknowledges the entries it sends to execution. A separate completion input frees a station at writeback. A store frees its station this way without driving the result bus. The execution units, the rename table and the register file are all outside the block.

Top module: `rs_array`

## Requirements
- R1: After reset no station is busy, the ready mask is zero and every tag output reads zero.
- R2: With default parameters station tags are 1 to 5: tag 1 is the integer ALU (unit code 0), tag 2 load (code 1), tag 3 store (code 2), tags 4 and 5 floating point (code 3). Dispatch takes the lowest-numbered free station of the requested unit and reports its tag on `disp_tag`.
- R3: When no station of the requested unit is free, `disp_ready` is low, `disp_tag` is zero and a dispatch attempt changes no station.
- R4: At dispatch, an operand with tag zero stores the supplied value; an operand with a nonzero tag stores that tag and waits.
- R5: A result broadcast clears every waiting source tag equal to the broadcast tag and stores the broadcast value in the next cycle, both sources of one entry included.
- R6: A broadcast carrying tag zero, or a tag on the bus while `bc_valid` is low, changes no station.
- R7: An entry whose last pending tag is on the bus is ready in that cycle, with the bus value on its issue value output.
- R8: If a source being dispatched names the tag on the bus in that same cycle, the entry stores the bus value with a zero tag.
- R9: A completion (`done_valid`, `done_tag`) frees that station with no result broadcast; dispatch may reuse a station freed in the same cycle.
- R10: An acknowledged ready entry stops being ready and stays busy until its completion.
- R11: An entry with a nonzero source tag is never ready unless that tag is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_unit | input | 2 | Requested unit: 0 ALU, 1 load, 2 store, 3 FP |
| disp_op | input | OP_W | Operation code |
| disp_dest | input | REG_W | Destination register name |
| disp_t1 | input | TAG_W | Source 1 tag, zero when value supplied |
| disp_v1 | input | DATA_W | Source 1 value |
| disp_t2 | input | TAG_W | Source 2 tag, zero when value supplied |
| disp_v2 | input | DATA_W | Source 2 value |
| disp_ready | output | 1 | A station of the requested unit is free |
| disp_tag | output | TAG_W | Tag of the station that would be allocated, zero if none |
| bc_valid | input | 1 | Result bus valid |
| bc_tag | input | TAG_W | Result bus tag |
| bc_value | input | DATA_W | Result bus value |
| done_valid | input | 1 | Station completion |
| done_tag | input | TAG_W | Tag of the completing station |
| iss_ready | output | NUM_RS | Entries with both operands available |
| iss_ack | input | NUM_RS | Entries taken by execution this cycle |
| iss_op | output | NUM_RS*OP_W | Per-entry operation |
| iss_dest | output | NUM_RS*REG_W | Per-entry destination register |
| iss_v1 | output | NUM_RS*DATA_W | Per-entry source 1 value, bus-forwarded |
| iss_v2 | output | NUM_RS*DATA_W | Per-entry source 2 value, bus-forwarded |
| st_busy | output | NUM_RS | Per-entry busy flag |
| st_t1 | output | NUM_RS*TAG_W | Per-entry stored source 1 tag |
| st_t2 | output | NUM_RS*TAG_W | Per-entry stored source 2 tag |

## Verification
The main pattern replays a short load, multiply, store and add-immediate loop twice. Every station's busy flag, tags and ready state are checked each cycle against a hand-worked schedule, which separates correct wakeup from late wakeup, stale tags and wrong station choice. Separate directed patterns put the same pending tag on both sources, put a null or unqualified tag on the bus, put a matching broadcast on the same cycle as dispatch, and keep a pending entry beside an unrelated broadcast. Each of these tells apart a design that compares one source, compares unqualified tags, misses the dispatch-cycle race or wakes without a match. Full-unit stalls and same-cycle free-and-reuse show whether allocation counts a freeing station as available.

// File: rtl/rs_pkg.sv
// Shared types for the reservation station array.
// Assumes stations are laid out by unit: ALU first, then load, store, FP.
package rs_pkg;

    typedef enum logic [1:0] {
        UNIT_ALU   = 2'd0,
        UNIT_LOAD  = 2'd1,
        UNIT_STORE = 2'd2,
        UNIT_FP    = 2'd3
    } unit_e;

    // Unit type of the station at zero-based index idx.
    function automatic unit_e station_unit(input int idx, input int n_alu,
                                           input int n_ld, input int n_st);
        if (idx < n_alu)
            return UNIT_ALU;
        else if (idx < n_alu + n_ld)
            return UNIT_LOAD;
        else if (idx < n_alu + n_ld + n_st)
            return UNIT_STORE;
        else
            return UNIT_FP;
    endfunction

endpackage

// File: rtl/rs_alloc.sv
// Station allocator: picks the lowest-index available station whose unit
// matches the request and returns it one-hot and as a tag (index + 1).
// Assumes avail already counts stations being freed this cycle.
module rs_alloc
    import rs_pkg::*;
#(
    parameter int NUM_RS = 5,
    parameter int N_ALU  = 1,
    parameter int N_LD   = 1,
    parameter int N_ST   = 1,
    parameter int TAG_W  = 3
) (
    input  logic [NUM_RS-1:0] avail,
    input  unit_e             req_unit,
    output logic [NUM_RS-1:0] grant,
    output logic              found,
    output logic [TAG_W-1:0]  tag
);

    int pick;

    // Scan downward so the lowest matching index wins.
    always_comb begin
        found = 1'b0;
        pick  = 0;
        for (int i = NUM_RS - 1; i >= 0; i--) begin
            if (avail[i] && station_unit(i, N_ALU, N_LD, N_ST) == req_unit) begin
                found = 1'b1;
                pick  = i;
            end
        end
        grant = found ? (NUM_RS'(1) << pick) : '0;
        tag   = found ? TAG_W'(pick + 1) : '0;
    end

endmodule

// File: rtl/rs_entry.sv
// One reservation station: holds op, destination and two operands, each as
// a value (tag zero) or a pending producer tag. Captures a matching result
// broadcast, forwards it for same-cycle issue, and frees on completion.
// Assumes at most one alloc per cycle and that alloc wins over free.
module rs_entry #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int REG_W  = 5,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [OP_W-1:0]   d_op,
    input  logic [REG_W-1:0]  d_dest,
    input  logic [TAG_W-1:0]  d_t1,
    input  logic [DATA_W-1:0] d_v1,
    input  logic [TAG_W-1:0]  d_t2,
    input  logic [DATA_W-1:0] d_v2,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              free_en,
    input  logic              issue_ack,
    output logic              busy_o,
    output logic              ready_o,
    output logic [OP_W-1:0]   op_o,
    output logic [REG_W-1:0]  dest_o,
    output logic [TAG_W-1:0]  t1_o,
    output logic [TAG_W-1:0]  t2_o,
    output logic [DATA_W-1:0] v1_o,
    output logic [DATA_W-1:0] v2_o
);

    logic              busy_q;
    logic              issued_q;
    logic [OP_W-1:0]   op_q;
    logic [REG_W-1:0]  dest_q;
    logic [TAG_W-1:0]  tag_q [2];
    logic [DATA_W-1:0] val_q [2];
    logic [TAG_W-1:0]  d_tag [2];
    logic [DATA_W-1:0] d_val [2];
    logic [1:0]        hit_now;
    logic [1:0]        d_hit;
    logic [1:0]        src_ok;
    logic              bc_live;

    assign d_tag[0] = d_t1;
    assign d_tag[1] = d_t2;
    assign d_val[0] = d_v1;
    assign d_val[1] = d_v2;
    assign bc_live  = bc_valid && (bc_tag != '0);

    // Compare stored and incoming source tags against the result bus.
    always_comb begin
        for (int s = 0; s < 2; s++) begin
            hit_now[s] = bc_live && (tag_q[s] == bc_tag);
            d_hit[s]   = bc_live && (d_tag[s] == bc_tag);
            src_ok[s]  = (tag_q[s] == '0) || hit_now[s];
        end
    end

    // Ready when busy, not yet sent, and both operands present or arriving.
    assign ready_o = busy_q && !issued_q && (&src_ok);
    assign busy_o  = busy_q;
    assign op_o    = op_q;
    assign dest_o  = dest_q;
    assign t1_o    = tag_q[0];
    assign t2_o    = tag_q[1];
    assign v1_o    = hit_now[0] ? bc_value : val_q[0];
    assign v2_o    = hit_now[1] ? bc_value : val_q[1];

    // Station state: allocate, free, mark issued and capture broadcasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            issued_q <= 1'b0;
            op_q     <= '0;
            dest_q   <= '0;
            for (int s = 0; s < 2; s++) begin
                tag_q[s] <= '0;
                val_q[s] <= '0;
            end
        end else if (alloc_en) begin
            busy_q   <= 1'b1;
            issued_q <= 1'b0;
            op_q     <= d_op;
            dest_q   <= d_dest;
            for (int s = 0; s < 2; s++) begin
                if (d_hit[s]) begin
                    tag_q[s] <= '0;
                    val_q[s] <= bc_value;
                end else begin
                    tag_q[s] <= d_tag[s];
                    val_q[s] <= (d_tag[s] == '0) ? d_val[s] : '0;
                end
            end
        end else if (free_en) begin
            busy_q   <= 1'b0;
            issued_q <= 1'b0;
            for (int s = 0; s < 2; s++)
                tag_q[s] <= '0;
        end else begin
            if (issue_ack && ready_o)
                issued_q <= 1'b1;
            for (int s = 0; s < 2; s++) begin
                if (busy_q && hit_now[s]) begin
                    tag_q[s] <= '0;
                    val_q[s] <= bc_value;
                end
            end
        end
    end

    // R5: a waiting source 1 captures the matching broadcast.
    p_capture_src1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && bc_valid && (bc_tag != '0) && (tag_q[0] == bc_tag)
        && !alloc_en && !free_en
        |=> (tag_q[0] == '0) && (val_q[0] == $past(bc_value)));

    // R5: a waiting source 2 captures the matching broadcast.
    p_capture_src2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && bc_valid && (bc_tag != '0) && (tag_q[1] == bc_tag)
        && !alloc_en && !free_en
        |=> (tag_q[1] == '0) && (val_q[1] == $past(bc_value)));

    // R11: a pending source blocks readiness unless its tag is on the bus.
    p_no_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_q[0] != '0) && !(bc_valid && bc_tag == tag_q[0]) |-> !ready_o);

    // R10: once acknowledged, the entry is not offered again.
    p_issue_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && issue_ack && !alloc_en && !free_en |=> busy_q && !ready_o);

    // R10: readiness implies occupancy.
    p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> busy_q);

endmodule

// File: rtl/rs_array.sv
// Reservation station array: typed stations, one dispatch per cycle into
// the lowest free station of the requested unit, result-bus wakeup with
// same-cycle forwarding, completion-driven free with same-cycle reuse.
// Assumes one result bus and one completion per cycle; select is external.
module rs_array
    import rs_pkg::*;
#(
    parameter int N_ALU  = 1,
    parameter int N_LD   = 1,
    parameter int N_ST   = 1,
    parameter int N_FP   = 2,
    parameter int DATA_W = 32,
    parameter int OP_W   = 4,
    parameter int REG_W  = 5,
    localparam int NUM_RS = N_ALU + N_LD + N_ST + N_FP,
    localparam int TAG_W  = $clog2(NUM_RS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     disp_valid,
    input  logic [1:0]               disp_unit,
    input  logic [OP_W-1:0]          disp_op,
    input  logic [REG_W-1:0]         disp_dest,
    input  logic [TAG_W-1:0]         disp_t1,
    input  logic [DATA_W-1:0]        disp_v1,
    input  logic [TAG_W-1:0]         disp_t2,
    input  logic [DATA_W-1:0]        disp_v2,
    output logic                     disp_ready,
    output logic [TAG_W-1:0]         disp_tag,
    input  logic                     bc_valid,
    input  logic [TAG_W-1:0]         bc_tag,
    input  logic [DATA_W-1:0]        bc_value,
    input  logic                     done_valid,
    input  logic [TAG_W-1:0]         done_tag,
    output logic [NUM_RS-1:0]        iss_ready,
    input  logic [NUM_RS-1:0]        iss_ack,
    output logic [NUM_RS*OP_W-1:0]   iss_op,
    output logic [NUM_RS*REG_W-1:0]  iss_dest,
    output logic [NUM_RS*DATA_W-1:0] iss_v1,
    output logic [NUM_RS*DATA_W-1:0] iss_v2,
    output logic [NUM_RS-1:0]        st_busy,
    output logic [NUM_RS*TAG_W-1:0]  st_t1,
    output logic [NUM_RS*TAG_W-1:0]  st_t2
);

    logic [NUM_RS-1:0] busy;
    logic [NUM_RS-1:0] free_hit;
    logic [NUM_RS-1:0] avail;
    logic [NUM_RS-1:0] grant;
    logic [NUM_RS-1:0] alloc_en;
    logic              found;
    logic [TAG_W-1:0]  grant_tag;

    // Pick the station for this cycle's dispatch.
    rs_alloc #(
        .NUM_RS (NUM_RS),
        .N_ALU  (N_ALU),
        .N_LD   (N_LD),
        .N_ST   (N_ST),
        .TAG_W  (TAG_W)
    ) u_alloc (
        .avail    (avail),
        .req_unit (unit_e'(disp_unit)),
        .grant    (grant),
        .found    (found),
        .tag      (grant_tag)
    );

    assign disp_ready = found;
    assign disp_tag   = grant_tag;
    assign st_busy    = busy;

    // One station per index; its tag is index + 1.
    for (genvar i = 0; i < NUM_RS; i++) begin : g_stn
        assign free_hit[i] = done_valid && (done_tag == TAG_W'(i + 1));
        assign avail[i]    = !busy[i] || free_hit[i];
        assign alloc_en[i] = disp_valid && grant[i];

        rs_entry #(
            .DATA_W (DATA_W),
            .OP_W   (OP_W),
            .REG_W  (REG_W),
            .TAG_W  (TAG_W)
        ) u_entry (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_en  (alloc_en[i]),
            .d_op      (disp_op),
            .d_dest    (disp_dest),
            .d_t1      (disp_t1),
            .d_v1      (disp_v1),
            .d_t2      (disp_t2),
            .d_v2      (disp_v2),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_value  (bc_value),
            .free_en   (free_hit[i]),
            .issue_ack (iss_ack[i]),
            .busy_o    (busy[i]),
            .ready_o   (iss_ready[i]),
            .op_o      (iss_op[i*OP_W +: OP_W]),
            .dest_o    (iss_dest[i*REG_W +: REG_W]),
            .t1_o      (st_t1[i*TAG_W +: TAG_W]),
            .t2_o      (st_t2[i*TAG_W +: TAG_W]),
            .v1_o      (iss_v1[i*DATA_W +: DATA_W]),
            .v2_o      (iss_v2[i*DATA_W +: DATA_W])
        );
    end

    // R2: at most one station is chosen per cycle.
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: an accepted dispatch makes the chosen station busy.
    p_alloc_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && disp_ready |=> ((busy & $past(grant)) == $past(grant)));

    // R3: a stalled dispatch with no completion leaves occupancy unchanged.
    p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready && !done_valid |=> busy == $past(busy));

endmodule

// File: tb/rs_array_tb.sv
module rs_array_tb;

    localparam int NR = 5;
    localparam int TW = 3;
    localparam int DW = 32;
    localparam int OW = 4;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          disp_valid;
    logic [1:0]    disp_unit;
    logic [OW-1:0] disp_op;
    logic [RW-1:0] disp_dest;
    logic [TW-1:0] disp_t1, disp_t2;
    logic [DW-1:0] disp_v1, disp_v2;
    logic          disp_ready;
    logic [TW-1:0] disp_tag;
    logic          bc_valid;
    logic [TW-1:0] bc_tag;
    logic [DW-1:0] bc_value;
    logic          done_valid;
    logic [TW-1:0] done_tag;
    logic [NR-1:0] iss_ready, iss_ack, st_busy;
    logic [NR*OW-1:0] iss_op;
    logic [NR*RW-1:0] iss_dest;
    logic [NR*DW-1:0] iss_v1, iss_v2;
    logic [NR*TW-1:0] st_t1, st_t2;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rs_array u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_unit(disp_unit), .disp_op(disp_op),
        .disp_dest(disp_dest), .disp_t1(disp_t1), .disp_v1(disp_v1),
        .disp_t2(disp_t2), .disp_v2(disp_v2),
        .disp_ready(disp_ready), .disp_tag(disp_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .done_valid(done_valid), .done_tag(done_tag),
        .iss_ready(iss_ready), .iss_ack(iss_ack), .iss_op(iss_op),
        .iss_dest(iss_dest), .iss_v1(iss_v1), .iss_v2(iss_v2),
        .st_busy(st_busy), .st_t1(st_t1), .st_t2(st_t2)
    );

    function automatic logic [TW-1:0] t1_of(input int i);
        return st_t1[i*TW +: TW];
    endfunction
    function automatic logic [TW-1:0] t2_of(input int i);
        return st_t2[i*TW +: TW];
    endfunction
    function automatic logic [DW-1:0] v1_of(input int i);
        return iss_v1[i*DW +: DW];
    endfunction
    function automatic logic [DW-1:0] v2_of(input int i);
        return iss_v2[i*DW +: DW];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid = 1'b0; disp_unit = 2'd0; disp_op = '0; disp_dest = '0;
        disp_t1 = '0; disp_v1 = '0; disp_t2 = '0; disp_v2 = '0;
        bc_valid = 1'b0; bc_tag = '0; bc_value = '0;
        done_valid = 1'b0; done_tag = '0; iss_ack = '0;
    endtask

    task automatic disp(input logic [1:0] u, input logic [OW-1:0] op,
                        input logic [RW-1:0] dst,
                        input logic [TW-1:0] t1, input logic [DW-1:0] v1,
                        input logic [TW-1:0] t2, input logic [DW-1:0] v2);
        disp_valid = 1'b1; disp_unit = u; disp_op = op; disp_dest = dst;
        disp_t1 = t1; disp_v1 = v1; disp_t2 = t2; disp_v2 = v2;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
        bc_valid = 1'b1; bc_tag = t; bc_value = v;
    endtask

    task automatic done(input logic [TW-1:0] t);
        done_valid = 1'b1; done_tag = t;
    endtask

    // Free every station through the completion input only (R9).
    task automatic drain();
        for (int t = 1; t <= NR; t++) begin
            idle();
            done(TW'(t));
            cyc();
        end
        idle();
        chk("R9", "drain busy", st_busy, 5'b00000);
    endtask

    task automatic t_reset();
        chk("R1", "busy", st_busy, 5'b00000);
        chk("R1", "ready", iss_ready, 5'b00000);
        chk("R1", "tags", {st_t1, st_t2}, '0);
        disp_unit = 2'd3;
        #1;
        chk("R2", "fp tag", {disp_ready, disp_tag}, {1'b1, 3'd4});
        disp_unit = 2'd0;
        #1;
        chk("R2", "alu tag", {disp_ready, disp_tag}, {1'b1, 3'd1});
        idle();
    endtask

    task automatic t_replay();
        // load f1 <- [r1], r1 = 100
        disp(2'd1, 4'd1, 5'd1, 3'd0, 32'd100, 3'd0, 32'd0);
        #1 chk("R2", "load tag", disp_tag, 3'd2);
        cyc(); idle();
        chk("R2", "busy A", st_busy, 5'b00010);
        chk("R4", "ready A", iss_ready, 5'b00010);
        chk("R4", "load v1", v1_of(1), 32'd100);
        // mul f2 <- f0(7) * f1(pending tag 2); load is sent
        disp(2'd3, 4'd2, 5'd2, 3'd0, 32'd7, 3'd2, 32'd0);
        iss_ack = 5'b00010;
        #1 chk("R2", "mul tag", disp_tag, 3'd4);
        cyc(); idle();
        chk("R2", "busy B", st_busy, 5'b01010);
        chk("R4", "mul t2", t2_of(3), 3'd2);
        chk("R10", "ready B", iss_ready, 5'b00000);
        // store f2(pending tag 4) -> [r1]
        disp(2'd2, 4'd3, 5'd0, 3'd4, 32'd0, 3'd0, 32'd100);
        #1 chk("R2", "store tag", disp_tag, 3'd3);
        cyc(); idle();
        chk("R4", "store t1", t1_of(2), 3'd4);
        chk("R2", "busy C", st_busy, 5'b01110);
        // load completes: broadcast 55; add-immediate dispatched
        bcast(3'd2, 32'd55); done(3'd2);
        disp(2'd0, 4'd4, 5'd9, 3'd0, 32'd100, 3'd0, 32'd4);
        iss_ack = 5'b01000;
        #1;
        chk("R7", "ready D", iss_ready, 5'b01000);
        chk("R7", "mul v2 fwd", v2_of(3), 32'd55);
        chk("R7", "mul v1", v1_of(3), 32'd7);
        chk("R2", "mul op/dest", {iss_op[3*OW +: OW], iss_dest[3*RW +: RW]},
            {4'd2, 5'd2});
        cyc(); idle();
        chk("R9", "busy D", st_busy, 5'b01101);
        chk("R5", "mul t2 cleared", t2_of(3), 3'd0);
        chk("R10", "ready D+", iss_ready, 5'b00001);
        // second load waits on the add (tag 1) and reuses station 2
        disp(2'd1, 4'd1, 5'd1, 3'd1, 32'd0, 3'd0, 32'd0);
        iss_ack = 5'b00001;
        #1 chk("R9", "reload tag", disp_tag, 3'd2);
        cyc(); idle();
        chk("R2", "busy E", st_busy, 5'b01111);
        chk("R11", "ready E", iss_ready, 5'b00000);
        // second multiply waits on tag 2
        disp(2'd3, 4'd2, 5'd2, 3'd0, 32'd7, 3'd2, 32'd0);
        #1 chk("R2", "mul2 tag", disp_tag, 3'd5);
        cyc(); idle();
        chk("R2", "busy F", st_busy, 5'b11111);
        chk("R4", "mul2 t2", t2_of(4), 3'd2);
        // add completes (104); a store request must stall
        bcast(3'd1, 32'd104); done(3'd1);
        disp(2'd2, 4'd3, 5'd0, 3'd5, 32'd0, 3'd0, 32'd104);
        #1;
        chk("R3", "store stall", {disp_ready, disp_tag}, {1'b0, 3'd0});
        chk("R7", "ready G", iss_ready, 5'b00010);
        chk("R7", "reload v1", v1_of(1), 32'd104);
        cyc(); idle();
        chk("R3", "busy G", st_busy, 5'b11110);
        chk("R5", "reload t1", t1_of(1), 3'd0);
        chk("R3", "store kept", t1_of(2), 3'd4);
        // first multiply completes (385); load sent
        bcast(3'd4, 32'd385); done(3'd4);
        iss_ack = 5'b00010;
        #1 chk("R7", "ready H", iss_ready, 5'b00110);
        cyc(); idle();
        chk("R9", "busy H", st_busy, 5'b10110);
        chk("R5", "store v1", v1_of(2), 32'd385);
        chk("R10", "ready H+", iss_ready, 5'b00100);
        // second load completes (60); store and mul2 sent
        bcast(3'd2, 32'd60); done(3'd2);
        iss_ack = 5'b10100;
        #1;
        chk("R7", "ready I", iss_ready, 5'b10100);
        chk("R7", "mul2 v2 fwd", v2_of(4), 32'd60);
        cyc(); idle();
        chk("R9", "busy I", st_busy, 5'b10100);
        chk("R10", "ready I+", iss_ready, 5'b00000);
        // store completes with no broadcast; second store reuses station 3
        done(3'd3);
        disp(2'd2, 4'd3, 5'd0, 3'd5, 32'd0, 3'd0, 32'd104);
        #1 chk("R9", "reuse tag", {disp_ready, disp_tag}, {1'b1, 3'd3});
        cyc(); idle();
        chk("R9", "busy J", st_busy, 5'b10100);
        chk("R9", "store2 t1", t1_of(2), 3'd5);
        chk("R4", "store2 v2", v2_of(2), 32'd104);
        chk("R11", "ready J", iss_ready, 5'b00000);
        drain();
    endtask

    task automatic t_stall();
        disp(2'd3, 4'd2, 5'd3, 3'd0, 32'd1, 3'd0, 32'd2);
        cyc();
        disp(2'd3, 4'd2, 5'd4, 3'd0, 32'd1, 3'd0, 32'd2);
        cyc();
        disp(2'd3, 4'd2, 5'd5, 3'd0, 32'd9, 3'd0, 32'd9);
        #1 chk("R3", "fp full", {disp_ready, disp_tag}, {1'b0, 3'd0});
        cyc();
        chk("R3", "busy held", st_busy, 5'b11000);
        chk("R3", "fp4 v1 held", v1_of(3), 32'd1);
        disp_unit = 2'd1;
        #1 chk("R2", "load free", {disp_ready, disp_tag}, {1'b1, 3'd2});
        idle();
        drain();
    endtask

    task automatic t_same_tag();
        disp(2'd0, 4'd4, 5'd6, 3'd0, 32'd3, 3'd0, 32'd3);
        cyc();
        disp(2'd3, 4'd2, 5'd7, 3'd1, 32'd0, 3'd1, 32'd0);
        cyc(); idle();
        chk("R4", "both pending", {t1_of(3), t2_of(3)}, {3'd1, 3'd1});
        bcast(3'd1, 32'd9);
        #1;
        chk("R7", "both ready", iss_ready, 5'b01001);
        chk("R5", "both fwd", {v1_of(3), v2_of(3)}, {32'd9, 32'd9});
        cyc(); idle();
        chk("R5", "both cleared", {t1_of(3), t2_of(3)}, {3'd0, 3'd0});
        chk("R5", "both values", {v1_of(3), v2_of(3)}, {32'd9, 32'd9});
        drain();
    endtask

    task automatic t_null_bcast();
        disp(2'd3, 4'd2, 5'd1, 3'd3, 32'd0, 3'd0, 32'd1);
        cyc(); idle();
        bcast(3'd0, 32'd77);
        #1 chk("R6", "tag0 ready", iss_ready, 5'b00000);
        cyc(); idle();
        chk("R6", "tag0 t1", t1_of(3), 3'd3);
        bc_valid = 1'b0; bc_tag = 3'd3; bc_value = 32'd77;
        #1 chk("R6", "invalid ready", iss_ready, 5'b00000);
        cyc(); idle();
        chk("R6", "invalid t1", t1_of(3), 3'd3);
        drain();
    endtask

    task automatic t_disp_capture();
        bcast(3'd2, 32'd33);
        disp(2'd3, 4'd2, 5'd1, 3'd2, 32'd0, 3'd0, 32'd5);
        cyc(); idle();
        chk("R8", "t1 zero", t1_of(3), 3'd0);
        chk("R8", "ready", iss_ready, 5'b01000);
        chk("R8", "v1", v1_of(3), 32'd33);
        drain();
    endtask

    task automatic t_no_bypass();
        disp(2'd3, 4'd2, 5'd1, 3'd1, 32'd0, 3'd0, 32'd5);
        cyc(); idle();
        for (int k = 0; k < 3; k++) begin
            bcast(3'd2, 32'd8);
            #1 chk("R11", "other tag", iss_ready, 5'b00000);
            cyc(); idle();
            chk("R11", "still pending", t1_of(3), 3'd1);
        end
        drain();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        t_reset();
        t_replay();
        t_replay();
        t_stall();
        t_same_tag();
        t_null_bcast();
        t_disp_capture();
        t_no_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule